// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block executes the two floating-point compare instructions of a 16-bit instruction set: an equality test and a strict greater-than test. It compares either two single-precision or two double-precision IEEE-754 values and writes a one-bit truth flag. A mode input selects the precision. In single mode only the low 32 bits of each operand bus carry meaning. In double mode the full 64 bits form one operand, and each register field must name an even register pair.

The unit decodes the instruction word. Each register field goes straight out so that an external register file can return the two operands in the same cycle. Each accepted compare first clears the invalid-operation cause bit and then sets it again if that compare was invalid. The equality test reports invalid only for a signaling NaN. The greater-than test reports invalid for any NaN operand. When an invalid compare has its exception enabled, the truth flag keeps its old value so that a trap handler sees the flag as it was. When the exception is disabled, the flag is written as 0.

A two-state controller tracks completion. The states are `ST_IDLE` (no compare finished in the previous cycle) and `ST_DONE` (the results of the compare accepted in the previous cycle are on the outputs). An accepted compare moves the controller from either state to `ST_DONE`. A cycle with no accepted compare moves it from either state to `ST_IDLE`.

Top module: `fcmp_unit`

## Requirements
- R1: After reset, `t_flag`, `cause_inv` and `cmp_done` are all 0.
- R2: With `issue` high, the word `1111 nnnn mmmm 0100` is accepted as an equality compare and `1111 nnnn mmmm 0101` as a greater-than compare. Any other word is ignored: `cmp_done` stays 0 and `t_flag` and `cause_inv` keep their values. `rn_sel` always equals word bits 11:8 and `rm_sel` always equals word bits 7:4.
- R3: With `dbl_mode` = 0, each operand is the single-precision value in bits 31:0 of its bus, and bits 63:32 have no effect. With `dbl_mode` = 1, each operand is the double-precision value in bits 63:0.
- R4: With `dbl_mode` = 1, a compare word that has bit 8 or bit 4 set (an odd register in either field) is ignored in the same way as in R2. In single mode, such a word is accepted.
- R5: For an equality compare of two non-NaN operands, the flag becomes 1 exactly when the values are arithmetically equal. +0 and -0 count as equal. If either operand is a NaN, the result is 0.
- R6: For a greater-than compare of two non-NaN operands, the flag becomes 1 exactly when operand n is strictly greater than operand m. The order is the sign-magnitude order: a negative value is below any positive value, and infinities are at the extremes. Neither zero is greater than the other.
- R7: A value is a NaN when its exponent field is all ones and its fraction is nonzero. It is a signaling NaN when the fraction MSB is 0 and a quiet NaN when that bit is 1. An equality compare is invalid exactly when either operand is a signaling NaN.
- R8: A greater-than compare is invalid exactly when either operand is a NaN of either kind.
- R9: Every accepted compare replaces `cause_inv` with that compare's invalid condition. A value left over from an earlier compare never survives an accepted compare.
- R10: For an invalid compare, `t_flag` keeps its previous value when `trap_inv_en` = 1 and is written as 0 when `trap_inv_en` = 0.
- R11: The new `t_flag`, the new `cause_inv` and `cmp_done` = 1 all appear in the cycle after the one in which the compare is accepted. `cmp_done` is 0 in any cycle that does not follow an accepted compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | The instruction word is presented this cycle |
| insn | input | 16 | Instruction word |
| dbl_mode | input | 1 | 0 = single precision, 1 = double precision |
| trap_inv_en | input | 1 | Invalid-operation exception enable |
| opnd_n | input | 64 | Operand n (low 32 bits in single mode) |
| opnd_m | input | 64 | Operand m (low 32 bits in single mode) |
| rn_sel | output | 4 | Register field n, for the register file read |
| rm_sel | output | 4 | Register field m, for the register file read |
| t_flag | output | 1 | Compare truth flag |
| cause_inv | output | 1 | Invalid-operation cause of the last accepted compare |
| cmp_done | output | 1 | High in the cycle after an accepted compare |

## Verification
The assertions assume that `issue`, `insn`, `dbl_mode` and `trap_inv_en` never carry unknown values after reset. The acceptance check in the properties is rebuilt from those ports alone, and the trap-enable properties look one cycle back at `trap_inv_en`, so they also assume that this input was defined in the issue cycle. The bench drives every input to a defined value at the falling edge and holds it for the whole cycle. In single mode it puts non-zero filler in the upper operand bits, and when no compare is being issued it keeps `issue` low.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    // Fixed instruction-word fields (other units decode the same layout)
    localparam logic [3:0] OPC_MAJOR = 4'hF;
    localparam logic [3:0] FUNC_EQ   = 4'h4;
    localparam logic [3:0] FUNC_GT   = 4'h5;
    localparam int         RN_LSB    = 8;
    localparam int         RM_LSB    = 4;
    localparam int         IDX_W     = 4;

    typedef enum logic [1:0] {
        CMP_NONE = 2'd0,
        CMP_EQ   = 2'd1,
        CMP_GT   = 2'd2
    } cmp_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } fcmp_state_e;

    typedef struct packed {
        logic sign;
        logic nan;
        logic snan;
        logic zero;
    } fp_class_t;

endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
    import fcmp_pkg::*;
#(
    parameter int INSN_W = 16
) (
    input  logic [INSN_W-1:0] insn,
    input  logic              dbl_mode,
    output cmp_op_e           op,
    output logic [IDX_W-1:0]  rn_sel,
    output logic [IDX_W-1:0]  rm_sel,
    output logic              pair_ok
);
    localparam int MAJ_LSB = INSN_W - 4;

    assign rn_sel = insn[RN_LSB +: IDX_W];
    assign rm_sel = insn[RM_LSB +: IDX_W];

    // Double operands live in even register pairs: field LSBs must be 0
    assign pair_ok = !dbl_mode || (!insn[RN_LSB] && !insn[RM_LSB]);

    always_comb begin
        op = CMP_NONE;
        if (insn[MAJ_LSB +: 4] == OPC_MAJOR) begin
            unique case (insn[3:0])
                FUNC_EQ: op = CMP_EQ;
                FUNC_GT: op = CMP_GT;
                default: op = CMP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]   value,
    output fp_class_t               cls,
    output logic [EXP_W+FRAC_W-1:0] mag
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              frac_nz;

    assign exp_f   = value[MAG_W-1 -: EXP_W];
    assign frac_f  = value[FRAC_W-1:0];
    assign exp_max = &exp_f;
    assign frac_nz = |frac_f;
    assign mag     = value[MAG_W-1:0];

    always_comb begin
        cls.sign = value[MAG_W];
        cls.nan  = exp_max && frac_nz;
        cls.snan = exp_max && frac_nz && !frac_f[FRAC_W-1];
        cls.zero = (mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  fp_class_t        cls_n,
    input  fp_class_t        cls_m,
    input  logic [MAG_W-1:0] mag_n,
    input  logic [MAG_W-1:0] mag_m,
    output logic             is_eq,
    output logic             is_gt,
    output logic             unordered,
    output logic             sig_nan
);
    logic both_zero;
    logic same_sign;

    assign both_zero = cls_n.zero && cls_m.zero;
    assign same_sign = (cls_n.sign == cls_m.sign);
    assign unordered = cls_n.nan || cls_m.nan;
    assign sig_nan   = cls_n.snan || cls_m.snan;

    always_comb begin
        is_eq = !unordered && (both_zero || (same_sign && (mag_n == mag_m)));
        if (unordered || both_zero) begin
            is_gt = 1'b0;
        end else if (!same_sign) begin
            is_gt = !cls_n.sign;
        end else if (!cls_n.sign) begin
            is_gt = (mag_n > mag_m);
        end else begin
            is_gt = (mag_n < mag_m);
        end
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    parameter int INSN_W    = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                issue,
    input  logic [INSN_W-1:0]                   insn,
    input  logic                                dbl_mode,
    input  logic                                trap_inv_en,
    input  logic [DP_EXP_W+DP_FRAC_W:0]         opnd_n,
    input  logic [DP_EXP_W+DP_FRAC_W:0]         opnd_m,
    output logic [3:0]                          rn_sel,
    output logic [3:0]                          rm_sel,
    output logic                                t_flag,
    output logic                                cause_inv,
    output logic                                cmp_done
);
    localparam int SP_W   = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W   = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int SP_MAG = SP_W - 1;
    localparam int DP_MAG = DP_W - 1;
    localparam int N_OPS  = 2;  // index 0 = operand n, 1 = operand m

    cmp_op_e     op;
    logic        pair_ok;
    logic        accept;
    fcmp_state_e state_q, state_d;

    fcmp_decode #(.INSN_W(INSN_W)) u_decode (
        .insn     (insn),
        .dbl_mode (dbl_mode),
        .op       (op),
        .rn_sel   (rn_sel),
        .rm_sel   (rm_sel),
        .pair_ok  (pair_ok)
    );

    // Operand classification, one classifier per operand and precision
    logic [DP_W-1:0]   opnd_arr [N_OPS];
    fp_class_t         sp_cls   [N_OPS];
    fp_class_t         dp_cls   [N_OPS];
    logic [SP_MAG-1:0] sp_mag   [N_OPS];
    logic [DP_MAG-1:0] dp_mag   [N_OPS];

    assign opnd_arr[0] = opnd_n;
    assign opnd_arr[1] = opnd_m;

    for (genvar k = 0; k < N_OPS; k++) begin : g_cls
        fcmp_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
            .value (opnd_arr[k][SP_W-1:0]),
            .cls   (sp_cls[k]),
            .mag   (sp_mag[k])
        );
        fcmp_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
            .value (opnd_arr[k]),
            .cls   (dp_cls[k]),
            .mag   (dp_mag[k])
        );
    end

    logic sp_eq, sp_gt, sp_unord, sp_snan;
    logic dp_eq, dp_gt, dp_unord, dp_snan;

    fcmp_order #(.MAG_W(SP_MAG)) u_sp_order (
        .cls_n     (sp_cls[0]),
        .cls_m     (sp_cls[1]),
        .mag_n     (sp_mag[0]),
        .mag_m     (sp_mag[1]),
        .is_eq     (sp_eq),
        .is_gt     (sp_gt),
        .unordered (sp_unord),
        .sig_nan   (sp_snan)
    );

    fcmp_order #(.MAG_W(DP_MAG)) u_dp_order (
        .cls_n     (dp_cls[0]),
        .cls_m     (dp_cls[1]),
        .mag_n     (dp_mag[0]),
        .mag_m     (dp_mag[1]),
        .is_eq     (dp_eq),
        .is_gt     (dp_gt),
        .unordered (dp_unord),
        .sig_nan   (dp_snan)
    );

    // Precision select and per-operation result / invalid condition
    logic sel_eq, sel_gt, sel_unord, sel_snan;
    logic cmp_res, cmp_inv;

    assign sel_eq    = dbl_mode ? dp_eq    : sp_eq;
    assign sel_gt    = dbl_mode ? dp_gt    : sp_gt;
    assign sel_unord = dbl_mode ? dp_unord : sp_unord;
    assign sel_snan  = dbl_mode ? dp_snan  : sp_snan;

    always_comb begin
        unique case (op)
            CMP_EQ: begin
                cmp_res = sel_eq;
                cmp_inv = sel_snan;
            end
            CMP_GT: begin
                cmp_res = sel_gt;
                cmp_inv = sel_unord;
            end
            default: begin
                cmp_res = 1'b0;
                cmp_inv = 1'b0;
            end
        endcase
    end

    assign accept = issue && (op != CMP_NONE) && pair_ok;

    // Controller: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = accept ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Architectural outputs: cause replaced, flag written or held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_flag    <= 1'b0;
            cause_inv <= 1'b0;
        end else if (accept) begin
            cause_inv <= cmp_inv;
            if (cmp_inv) begin
                t_flag <= trap_inv_en ? t_flag : 1'b0;
            end else begin
                t_flag <= cmp_res;
            end
        end
    end

    assign cmp_done = (state_q == ST_DONE);

endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        issue,
    input logic [15:0] insn,
    input logic        dbl_mode,
    input logic        trap_inv_en,
    input logic [63:0] opnd_n,
    input logic [63:0] opnd_m,
    input logic [3:0]  rn_sel,
    input logic [3:0]  rm_sel,
    input logic        t_flag,
    input logic        cause_inv,
    input logic        cmp_done
);
    logic is_cmp_word;
    logic odd_pair;
    logic acc;

    assign is_cmp_word = (insn[15:12] == 4'hF) && (insn[3:1] == 3'b010);
    assign odd_pair    = insn[8] || insn[4];
    assign acc         = issue && is_cmp_word && !(dbl_mode && odd_pair);

    // R11: completion follows an accepted compare by one cycle
    p_done_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> cmp_done);

    // R11: no completion without an accepted compare
    p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !cmp_done);

    // R2: ignored cycles leave flag and cause alone
    p_idle_holds_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(t_flag) && $stable(cause_inv)));

    // R4: odd register pair in double mode is rejected
    p_odd_pair_rejected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dbl_mode && odd_pair) |=> !cmp_done);

    // R10: enabled invalid keeps the previous flag
    p_trap_keeps_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && cause_inv && $past(trap_inv_en)) |-> (t_flag == $past(t_flag)));

    // R10: disabled invalid writes the flag as 0
    p_trap_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && cause_inv && !$past(trap_inv_en)) |-> !t_flag);

    // R2: register fields pass straight through
    always_comb begin
        if (rst_n) begin
            p_fields_pass_r2: assert ((rn_sel == insn[11:8]) && (rm_sel == insn[7:4]));
        end
    end
endmodule

bind fcmp_unit fcmp_checker i_fcmp_checker (.*);

// File: tb/test_fcmp_unit.sv
`timescale 1ns/1ps
module test_fcmp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] insn = '0;
    logic        dbl_mode = 1'b0;
    logic        trap_inv_en = 1'b0;
    logic [63:0] opnd_n = '0;
    logic [63:0] opnd_m = '0;
    logic [3:0]  rn_sel, rm_sel;
    logic        t_flag, cause_inv, cmp_done;

    int n_chk  = 0;
    int n_fail = 0;
    logic exp_t = 1'b0;
    logic exp_c = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fcmp_unit i_fcmp_unit (
        .clk, .rst_n, .issue, .insn, .dbl_mode, .trap_inv_en,
        .opnd_n, .opnd_m, .rn_sel, .rm_sel, .t_flag, .cause_inv, .cmp_done
    );

    function automatic logic [31:0] sp_pat(input int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h8000_0000;
            2: return 32'h0000_0001;  3: return 32'h8000_0001;
            4: return 32'h3F80_0000;  5: return 32'hBF80_0000;
            6: return 32'h3FC0_0000;  7: return 32'hBFC0_0000;
            8: return 32'h7F7F_FFFF;  9: return 32'hFF7F_FFFF;
            10: return 32'h7F80_0000; 11: return 32'hFF80_0000;
            12: return 32'h7FC0_0000; 13: return 32'h7F80_0001;
            14: return 32'hFFC0_0001; default: return 32'hFFA0_0000;
        endcase
    endfunction

    function automatic logic [63:0] dp_pat(input int i);
        case (i)
            0: return 64'h0000_0000_0000_0000;  1: return 64'h8000_0000_0000_0000;
            2: return 64'h0000_0000_0000_0001;  3: return 64'h8000_0000_0000_0001;
            4: return 64'h3FF0_0000_0000_0000;  5: return 64'hBFF0_0000_0000_0000;
            6: return 64'h3FF8_0000_0000_0000;  7: return 64'hBFF8_0000_0000_0000;
            8: return 64'h7FEF_FFFF_FFFF_FFFF;  9: return 64'hFFEF_FFFF_FFFF_FFFF;
            10: return 64'h7FF0_0000_0000_0000; 11: return 64'hFFF0_0000_0000_0000;
            12: return 64'h7FF8_0000_0000_0000; 13: return 64'h7FF0_0000_0000_0001;
            14: return 64'hFFF8_0000_0000_0001; default: return 64'hFFF4_0000_0000_0000;
        endcase
    endfunction

    // Arithmetic value of a single-precision pattern (non-NaN)
    function automatic real sp_value(input logic [31:0] b);
        int  e = int'(b[30:23]);
        real v;
        int  sc;
        if (e == 255) begin
            v = 1.0e300;
        end else begin
            v  = (e == 0) ? real'(b[22:0]) : real'({1'b1, b[22:0]});
            sc = ((e == 0) ? 1 : e) - 150;
            for (int s = 0; s < (sc < 0 ? -sc : sc); s++) v = (sc < 0) ? v / 2.0 : v * 2.0;
        end
        return b[31] ? -v : v;
    endfunction

    // Expected result and invalid condition from the requirements
    task automatic model(input logic dbl, input logic gt_op, input logic [63:0] a, input logic [63:0] b,
                         output logic res, output logic inv, output string tag);
        logic na, nb, sa, sb;
        real  va, vb;
        if (dbl) begin
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);  sa = na && !a[51];
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);  sb = nb && !b[51];
            va = $bitstoreal(a);  vb = $bitstoreal(b);
        end else begin
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0);  sa = na && !a[22];
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);  sb = nb && !b[22];
            va = na ? 0.0 : sp_value(a[31:0]);  vb = nb ? 0.0 : sp_value(b[31:0]);
        end
        if (gt_op) begin
            inv = na || nb;
            res = !(na || nb) && (va > vb);
            tag = (na || nb) ? "R8" : "R6";
        end else begin
            inv = sa || sb;
            res = !(na || nb) && (va == vb);
            tag = (na || nb) ? "R7" : "R5";
        end
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [2:0] act, input logic [2:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual {done,t,cause}=%b expected %b", tag, what, act, expv);
        end
    endtask

    // One issue cycle followed by one idle cycle
    task automatic issue_word(input logic [15:0] w, input logic dbl, input logic en,
                              input logic [63:0] a, input logic [63:0] b,
                              input bit acc_exp, input string tag);
        logic res, inv;
        string mtag;
        @(negedge clk);
        issue = 1'b1; insn = w; dbl_mode = dbl; trap_inv_en = en; opnd_n = a; opnd_m = b;
        #1;
        check((rn_sel == w[11:8]) && (rm_sel == w[7:4]), "R2", "register fields",
              {1'b0, rn_sel[0], rm_sel[0]}, {1'b0, w[8], w[4]});
        model(dbl, w[0], a, b, res, inv, mtag);
        if (acc_exp) begin
            exp_c = inv;
            if (inv) begin
                exp_t = en ? exp_t : 1'b0;
                mtag = {mtag, "/R9/R10"};
            end else begin
                exp_t = res;
            end
        end else begin
            mtag = tag;
        end
        @(negedge clk);
        issue = 1'b0;
        check((cmp_done == acc_exp) && (t_flag == exp_t) && (cause_inv == exp_c),
              acc_exp ? mtag : tag, acc_exp ? "compare result" : "ignored word",
              {cmp_done, t_flag, cause_inv}, {acc_exp, exp_t, exp_c});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({cmp_done, t_flag, cause_inv} == 3'b000, "R1", "reset state",
              {cmp_done, t_flag, cause_inv}, 3'b000);

        // R3 R5 R6 R7 R8 R9 R10: sweep all pattern pairs, both ops, both precisions, both enables
        for (int p = 0; p < 2; p++) begin
            for (int g = 0; g < 2; g++) begin
                for (int en = 0; en < 2; en++) begin
                    for (int i = 0; i < 16; i++) begin
                        for (int j = 0; j < 16; j++) begin
                            logic [63:0] a, b;
                            logic [15:0] w;
                            if (p == 1) begin
                                a = dp_pat(i); b = dp_pat(j);
                                w = {4'hF, 4'((i * 2) % 16), 4'((j * 2) % 16), 3'b010, 1'(g)};
                            end else begin
                                // R3: upper bits carry filler that must not matter
                                a = {32'hA5A5_0000 | 32'(i), sp_pat(i)};
                                b = {32'h5A5A_0000 | 32'(j), sp_pat(j)};
                                w = {4'hF, 4'(i), 4'(j), 3'b010, 1'(g)};
                            end
                            issue_word(w, 1'(p), 1'(en), a, b, 1'b1, "R3");
                        end
                    end
                end
            end
        end

        // Put flag at 1 and cause at 1, then offer ignored words (R2)
        issue_word(16'hF015, 1'b0, 1'b1, {32'h0, sp_pat(4)}, {32'h0, sp_pat(5)}, 1'b1, "R6");
        issue_word(16'hF014, 1'b0, 1'b1, {32'h0, sp_pat(13)}, {32'h0, sp_pat(4)}, 1'b1, "R10");
        issue_word(16'hF016, 1'b0, 1'b0, {32'h0, sp_pat(4)}, {32'h0, sp_pat(4)}, 1'b0, "R2");
        issue_word(16'hE014, 1'b0, 1'b0, {32'h0, sp_pat(4)}, {32'h0, sp_pat(4)}, 1'b0, "R2");
        issue_word(16'hF01C, 1'b0, 1'b0, {32'h0, sp_pat(4)}, {32'h0, sp_pat(4)}, 1'b0, "R2");

        // R4: odd register field in double mode is ignored; same word accepted in single mode
        issue_word(16'hF324, 1'b1, 1'b0, dp_pat(4), dp_pat(4), 1'b0, "R4");
        issue_word(16'hF234, 1'b1, 1'b0, dp_pat(4), dp_pat(4), 1'b0, "R4");
        issue_word(16'hF335, 1'b1, 1'b0, dp_pat(6), dp_pat(4), 1'b0, "R4");
        issue_word(16'hF334, 1'b0, 1'b0, {32'h0, sp_pat(4)}, {32'h0, sp_pat(4)}, 1'b1, "R4");

        // R9: a valid compare after an invalid one clears the cause
        issue_word(16'hF025, 1'b1, 1'b1, dp_pat(12), dp_pat(4), 1'b1, "R9");
        issue_word(16'hF025, 1'b1, 1'b1, dp_pat(4), dp_pat(5), 1'b1, "R9");

        // R11: completion drops in a cycle with no accepted compare
        @(negedge clk);
        check(cmp_done == 1'b0, "R11", "done after idle", {cmp_done, t_flag, cause_inv},
              {1'b0, exp_t, exp_c});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule